// File: doc/BRIEF.md
# Loop Count Branch Unit

This block resolves loop-closing branches on its own. It holds a private iteration counter that is not part of the general register file. Before a loop starts, software writes the trip count into this counter. Each time a loop-closing branch is issued, the block steps the counter down by one and tests the new value. From that test it decides the branch direction and the address to fetch next. No integer unit takes part, and no condition code has to arrive from elsewhere, so the fetch path is known one cycle after issue.

A mode input picks the sense of the test. In the normal sense the branch is taken while the decremented count is non-zero, which is the usual way to close a counted loop. In the inverted sense the branch is taken only when the count reaches zero. The outcome, the chosen fetch address and a one-cycle valid pulse are registered. The live counter value is always visible on an output.

Top module: `loopctr_branch_unit`

## Requirements
- R1: After reset the counter reads 0, the resolve-valid pulse is low, the taken flag is low and the next-fetch address is 0.
- R2: A counter load (`ld_valid_i` high) makes `count_o` equal to `ld_value_i` on the next cycle.
- R3: A branch issue with no load in the same cycle makes the counter one less than before, modulo 2^CNT_W. 0 steps to all ones and 32'h8000_0000 steps to 32'h7FFF_FFFF.
- R4: With `mode_zero_i` = 0, an issued branch is taken exactly when the decremented count is non-zero.
- R5: With `mode_zero_i` = 1, an issued branch is taken exactly when the decremented count is zero.
- R6: One cycle after an issue that is not overridden, `next_valid_o` is 1. In that same cycle `next_pc_o` is `br_target_i` if the branch is taken and `br_fallthru_i` if it is not, using the addresses sampled at issue.
- R7: When a load and a branch issue arrive in the same cycle, the load wins. The counter takes the load value with no decrement, `next_valid_o` stays 0, and `taken_o` and `next_pc_o` keep their previous values.
- R8: In a cycle with neither load nor issue, the counter holds, `next_valid_o` is 0, and `taken_o` and `next_pc_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid_i | input | 1 | Write `ld_value_i` into the counter |
| ld_value_i | input | CNT_W | Iteration count to load |
| br_issue_i | input | 1 | A decrement-and-branch is issued this cycle |
| mode_zero_i | input | 1 | 0: taken while non-zero; 1: taken on zero |
| br_target_i | input | ADDR_W | Branch target address |
| br_fallthru_i | input | ADDR_W | Sequential (fall-through) address |
| taken_o | output | 1 | Outcome of the last resolved branch |
| next_pc_o | output | ADDR_W | Next fetch address of the last resolved branch |
| next_valid_o | output | 1 | One-cycle pulse: a branch was resolved |
| count_o | output | CNT_W | Current counter value |

## Verification
The bench decrements the counter through 1 to 0, where the taken sense flips. A design that tested the old value instead of the new one would take one extra loop trip. It also steps the counter from 0 and from 32'h8000_0000 to expose a decrement that saturates or drops the top bit. A load arriving together with an issue checks that the counter is not loaded and then decremented, and that no spurious resolve pulse appears. The inverted mode is run with both outcomes, so a mode bit that is ignored or sampled in the wrong cycle shows up as a wrong fetch address.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

  typedef enum logic {
    TEST_NONZERO = 1'b0,
    TEST_ZERO    = 1'b1
  } test_mode_e;

  typedef enum logic [1:0] {
    OP_IDLE      = 2'd0,
    OP_LOAD      = 2'd1,
    OP_DEC       = 2'd2,
    OP_LOAD_WINS = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/lbu_op_decode.sv
module lbu_op_decode
  import lbu_pkg::*;
(
  input  logic    ld_valid_i,
  input  logic    br_issue_i,
  output cnt_op_e op_o,
  output logic    load_fire_o,
  output logic    dec_fire_o
);

  always_comb begin
    unique case ({ld_valid_i, br_issue_i})
      2'b10:   op_o = OP_LOAD;
      2'b01:   op_o = OP_DEC;
      2'b11:   op_o = OP_LOAD_WINS;
      default: op_o = OP_IDLE;
    endcase
  end

  assign load_fire_o = (op_o == OP_LOAD) || (op_o == OP_LOAD_WINS);
  assign dec_fire_o  = (op_o == OP_DEC);

endmodule

// File: rtl/lbu_count_reg.sv
module lbu_count_reg #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_fire_i,
  input  logic             dec_fire_i,
  input  logic [CNT_W-1:0] load_value_i,
  output logic [CNT_W-1:0] count_q_o,
  output logic [CNT_W-1:0] count_dec_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - ONE;
  endfunction

  logic [CNT_W-1:0] count_q;

  assign count_dec_o = step_down(count_q);
  assign count_q_o   = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (load_fire_i) begin
      count_q <= load_value_i;
    end else if (dec_fire_i) begin
      count_q <= count_dec_o;
    end
  end

endmodule

// File: rtl/lbu_resolve.sv
module lbu_resolve
  import lbu_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_fire_i,
  input  test_mode_e        mode_i,
  input  logic [CNT_W-1:0]  count_dec_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [ADDR_W-1:0] fallthru_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              next_valid_o
);

  function automatic logic decide(input test_mode_e m, input logic [CNT_W-1:0] v);
    logic is_zero;
    is_zero = (v == '0);
    return (m == TEST_ZERO) ? is_zero : !is_zero;
  endfunction

  function automatic logic [ADDR_W-1:0] pick_pc(input logic t,
                                               input logic [ADDR_W-1:0] tgt,
                                               input logic [ADDR_W-1:0] ft);
    return t ? tgt : ft;
  endfunction

  logic              taken_d;
  logic [ADDR_W-1:0] pc_d;

  assign taken_d = decide(mode_i, count_dec_i);
  assign pc_d    = pick_pc(taken_d, target_i, fallthru_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_o      <= 1'b0;
      next_pc_o    <= '0;
      next_valid_o <= 1'b0;
    end else begin
      next_valid_o <= dec_fire_i;
      if (dec_fire_i) begin
        taken_o   <= taken_d;
        next_pc_o <= pc_d;
      end
    end
  end

endmodule

// File: rtl/loopctr_branch_unit.sv
module loopctr_branch_unit
  import lbu_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid_i,
  input  logic [CNT_W-1:0]  ld_value_i,
  input  logic              br_issue_i,
  input  logic              mode_zero_i,
  input  logic [ADDR_W-1:0] br_target_i,
  input  logic [ADDR_W-1:0] br_fallthru_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              next_valid_o,
  output logic [CNT_W-1:0]  count_o
);

  cnt_op_e          op;
  logic             load_fire;
  logic             dec_fire;
  logic [CNT_W-1:0] count_dec;
  test_mode_e       mode;

  assign mode = mode_zero_i ? TEST_ZERO : TEST_NONZERO;

  lbu_op_decode u_dec (
    .ld_valid_i  (ld_valid_i),
    .br_issue_i  (br_issue_i),
    .op_o        (op),
    .load_fire_o (load_fire),
    .dec_fire_o  (dec_fire)
  );

  lbu_count_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_fire_i  (load_fire),
    .dec_fire_i   (dec_fire),
    .load_value_i (ld_value_i),
    .count_q_o    (count_o),
    .count_dec_o  (count_dec)
  );

  lbu_resolve #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_res (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_fire_i   (dec_fire),
    .mode_i       (mode),
    .count_dec_i  (count_dec),
    .target_i     (br_target_i),
    .fallthru_i   (br_fallthru_i),
    .taken_o      (taken_o),
    .next_pc_o    (next_pc_o),
    .next_valid_o (next_valid_o)
  );

endmodule

// File: rtl/lbu_checker.sv
module lbu_checker #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid_i,
  input logic [CNT_W-1:0]  ld_value_i,
  input logic              br_issue_i,
  input logic              mode_zero_i,
  input logic [ADDR_W-1:0] br_target_i,
  input logic [ADDR_W-1:0] br_fallthru_i,
  input logic              taken_o,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic              next_valid_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              load_fire,
  input logic              dec_fire
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_i |=> count_o == $past(ld_value_i));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_issue_i && !ld_valid_i) |=> count_o == $past(count_o) - ONE);

  p_taken_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_fire && !mode_zero_i) |=> taken_o == ($past(count_o) != ONE));

  p_taken_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_fire && mode_zero_i) |=> taken_o == ($past(count_o) == ONE));

  p_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |=> next_valid_o);

  p_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |=> next_pc_o == (taken_o ? $past(br_target_i) : $past(br_fallthru_i)));

  p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && br_issue_i) |=> (!next_valid_o && $stable(next_pc_o) && $stable(taken_o)));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_valid_i && !br_issue_i) |=> ($stable(count_o) && !next_valid_o && $stable(next_pc_o)));

endmodule

bind loopctr_branch_unit lbu_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ld_valid_i    (ld_valid_i),
  .ld_value_i    (ld_value_i),
  .br_issue_i    (br_issue_i),
  .mode_zero_i   (mode_zero_i),
  .br_target_i   (br_target_i),
  .br_fallthru_i (br_fallthru_i),
  .taken_o       (taken_o),
  .next_pc_o     (next_pc_o),
  .next_valid_o  (next_valid_o),
  .count_o       (count_o),
  .load_fire     (load_fire),
  .dec_fire      (dec_fire)
);

// File: tb/tb_loopctr_branch_unit.sv
`timescale 1ns/1ps
module tb_loopctr_branch_unit;

  localparam int CW = 32;
  localparam int AW = 32;

  typedef struct packed {
    logic          ld;
    logic [CW-1:0] ldv;
    logic          iss;
    logic          mode;
    logic [AW-1:0] tgt;
    logic [AW-1:0] ft;
    logic [CW-1:0] e_cnt;
    logic          e_val;
    logic          e_tak;
    logic [AW-1:0] e_pc;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'd3, 1'b0, 1'b0, 32'd0,   32'd0,   32'd3,          1'b0, 1'b0, 32'd0},
    '{1'b0, 32'd0, 1'b1, 1'b0, 32'd100, 32'd104, 32'd2,          1'b1, 1'b1, 32'd100},
    '{1'b0, 32'd0, 1'b1, 1'b0, 32'd200, 32'd204, 32'd1,          1'b1, 1'b1, 32'd200},
    '{1'b0, 32'd0, 1'b1, 1'b0, 32'd300, 32'd304, 32'd0,          1'b1, 1'b0, 32'd304},
    '{1'b0, 32'd0, 1'b0, 1'b0, 32'd999, 32'd999, 32'd0,          1'b0, 1'b0, 32'd304},
    '{1'b0, 32'd0, 1'b1, 1'b0, 32'd400, 32'd404, 32'hFFFF_FFFF,  1'b1, 1'b1, 32'd400},
    '{1'b1, 32'd1, 1'b1, 1'b0, 32'd500, 32'd504, 32'd1,          1'b0, 1'b1, 32'd400},
    '{1'b0, 32'd0, 1'b1, 1'b1, 32'd600, 32'd604, 32'd0,          1'b1, 1'b1, 32'd600},
    '{1'b1, 32'd5, 1'b0, 1'b1, 32'd0,   32'd0,   32'd5,          1'b0, 1'b1, 32'd600},
    '{1'b0, 32'd0, 1'b1, 1'b1, 32'd700, 32'd704, 32'd4,          1'b1, 1'b0, 32'd704},
    '{1'b0, 32'd0, 1'b1, 1'b0, 32'd800, 32'd804, 32'd3,          1'b1, 1'b1, 32'd800}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 8:    return "R2";
      1, 2:    return "R4/R6";
      3:       return "R4 zero-reached";
      4:       return "R8";
      5:       return "R3 wrap";
      6:       return "R7";
      7, 9:    return "R5";
      default: return "R6";
    endcase
  endfunction

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_valid_i, br_issue_i, mode_zero_i;
  logic [CW-1:0] ld_value_i;
  logic [AW-1:0] br_target_i, br_fallthru_i;
  logic          taken_o, next_valid_o;
  logic [AW-1:0] next_pc_o;
  logic [CW-1:0] count_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  loopctr_branch_unit #(.CNT_W(CW), .ADDR_W(AW)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_valid_i    (ld_valid_i),
    .ld_value_i    (ld_value_i),
    .br_issue_i    (br_issue_i),
    .mode_zero_i   (mode_zero_i),
    .br_target_i   (br_target_i),
    .br_fallthru_i (br_fallthru_i),
    .taken_o       (taken_o),
    .next_pc_o     (next_pc_o),
    .next_valid_o  (next_valid_o),
    .count_o       (count_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic [CW-1:0] v, input logic iss,
                       input logic m, input logic [AW-1:0] t, input logic [AW-1:0] f);
    ld_valid_i = ld; ld_value_i = v; br_issue_i = iss;
    mode_zero_i = m; br_target_i = t; br_fallthru_i = f;
  endtask

  task automatic check_all(input string tag, input logic [CW-1:0] c, input logic v,
                           input logic t, input logic [AW-1:0] p);
    check(tag, "count", 64'(count_o), 64'(c));
    check(tag, "valid", 64'(next_valid_o), 64'(v));
    check(tag, "taken", 64'(taken_o), 64'(t));
    check(tag, "next_pc", 64'(next_pc_o), 64'(p));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, '0, 1'b0, 1'b0, '0, '0);
    repeat (3) @(negedge clk);
    // R1: state straight after reset
    check_all("R1", '0, 1'b0, 1'b0, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].ld, VEC[i].ldv, VEC[i].iss, VEC[i].mode, VEC[i].tgt, VEC[i].ft);
      @(negedge clk);
      check_all(vec_tag(i), VEC[i].e_cnt, VEC[i].e_val, VEC[i].e_tak, VEC[i].e_pc);
    end

    // R3: step from the top bit, default mode taken
    drive(1'b1, 32'h8000_0000, 1'b0, 1'b0, '0, '0);
    @(negedge clk);
    drive(1'b0, '0, 1'b1, 1'b0, 32'hA0, 32'hA4);
    @(negedge clk);
    check_all("R3 msb", 32'h7FFF_FFFF, 1'b1, 1'b1, 32'hA0);

    // R5: inverted mode, count 1 -> 0 taken; then 0 -> wrap not taken
    drive(1'b1, 32'd1, 1'b0, 1'b0, '0, '0);
    @(negedge clk);
    drive(1'b0, '0, 1'b1, 1'b1, 32'hB0, 32'hB4);
    @(negedge clk);
    check_all("R5 hit", 32'd0, 1'b1, 1'b1, 32'hB0);
    drive(1'b0, '0, 1'b1, 1'b1, 32'hC0, 32'hC4);
    @(negedge clk);
    check_all("R5 wrap", 32'hFFFF_FFFF, 1'b1, 1'b0, 32'hC4);

    // R8: several idle cycles with noisy addresses
    drive(1'b0, '0, 1'b0, 1'b1, 32'hDEAD, 32'hBEEF);
    repeat (3) @(negedge clk);
    check_all("R8 hold", 32'hFFFF_FFFF, 1'b0, 1'b0, 32'hC4);

    // R1: reset in mid-run clears everything
    rst_n = 1'b0;
    drive(1'b1, 32'd9, 1'b1, 1'b0, 32'hE0, 32'hE4);
    @(negedge clk);
    check_all("R1 rerun", '0, 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    drive(1'b0, '0, 1'b0, 1'b0, '0, '0);
    @(negedge clk);

    finish_run();
  end

endmodule